// File: doc/BRIEF.md
# Reference Divider with Mode Control

This block turns one 3-bit mode code into the control signals of a frequency-synthesizer reference path. The code says whether the crystal oscillator runs, whether the reference counter may advance, and what the reference output pin carries. The output can be held low, can follow the reference, or can carry the reference divided by 2, 4, 8 or 16. A standby input halts the reference counter but leaves the oscillator running. The oscillator itself is not part of the block. It is represented only by its enable output.

The reference input is sampled on the block clock through a synchronizer, and its rising edges drive a toggle counter. This gives a 50% duty-cycle divided output. A new mode code does not act at once if a divided output is running. The switch waits until the current low phase ends, so no phase is ever cut short. After reset the divider divides by 8 until the first code change is taken up. The oscillator and counter enables follow the requested code one clock later.

Top module: `ref_divider_ctl`

## Requirements
- R1: While reset is asserted, `ref_out`, `osc_en` and `rcnt_en` are 0. After reset the active code is 6 (divide by 8) until the first adoption point.
- R2: Mode code 0 gives `osc_en`=0 and `rcnt_en`=0 one clock later, whatever the value of `standby`. `ref_out` is held at 0.
- R3: Mode code 1 gives `osc_en`=1 one clock later and holds `ref_out` at 0. `rcnt_en` is then 1 when `standby` is 0.
- R4: When `standby` is 1, `rcnt_en` is 0 one clock later. `osc_en` is not affected.
- R5: Mode code 2 holds `ref_out` at 0 and gives `osc_en`=0. `rcnt_en` is the inverse of `standby` (one clock later).
- R6: Mode code 3 gives divide by 1. `ref_out` goes high one clock after a synchronized rising edge of `ref_in` and goes low one clock after the synchronized level falls.
- R7: Codes 4, 5, 6 and 7 divide by 2, 4, 8 and 16. The output has equal high and low phases, each of N/2 synchronized rising edges of `ref_in`. `ref_out` only rises one clock after such an edge.
- R8: If the active code is 3..7, a different requested code is taken up only at the edge that ends a low phase. `ref_out` stays low at that point, so the next low phase starts at full length and no phase is shortened.
- R9: If the active code is 0, 1 or 2, a different requested code is taken up on the next clock. A divided or followed output then starts low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal to be divided (asynchronous to clk) |
| mode_code | input | 3 | Requested mode: 0 osc off, 1 crystal on, 2 output quiet, 3..7 divide by 1/2/4/8/16 |
| standby | input | 1 | Halts the reference counter; oscillator unaffected |
| osc_en | output | 1 | Crystal oscillator enable |
| rcnt_en | output | 1 | Reference counter enable |
| ref_out | output | 1 | Divided or followed reference output |

## Verification
The checker watches the enable decode on every cycle: the oscillator and counter enables for codes 0 and 1, and the effect of standby. It also checks on every cycle that the output stays quiet in the static modes, that the output rises only after a synchronized reference edge, and that the active code changes only while the output is low. Only the bench's scenarios can show the exact phase lengths for each ratio, the extra low phase that follows a mid-period code change, and the divide-by-8 behaviour that lasts from reset until the first adoption point. The bench compares these against its own cycle model at several reference speeds.

// File: rtl/ref_divider_pkg.sv
package ref_divider_pkg;

   localparam int CODE_W = 3;
   localparam int HALF_W = 3;

   typedef enum logic [CODE_W-1:0] {
      MD_XTAL_OFF  = 3'd0,
      MD_XTAL_ON   = 3'd1,
      MD_REF_QUIET = 3'd2,
      MD_DIV1      = 3'd3,
      MD_DIV2      = 3'd4,
      MD_DIV4      = 3'd5,
      MD_DIV8      = 3'd6,
      MD_DIV16     = 3'd7
   } refmode_e;

   // modes in which the output pin is held static
   function automatic logic mode_is_static(refmode_e m);
      return (m == MD_XTAL_OFF) || (m == MD_XTAL_ON) || (m == MD_REF_QUIET);
   endfunction

   // number of reference edges per half period, minus one
   function automatic logic [HALF_W-1:0] half_len_m1(refmode_e m);
      logic [HALF_W-1:0] r;
      case (m)
         MD_DIV2:  r = 3'd0;
         MD_DIV4:  r = 3'd1;
         MD_DIV8:  r = 3'd3;
         MD_DIV16: r = 3'd7;
         default:  r = 3'd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ref_divider_sync.sv
module ref_divider_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   output logic ref_lvl,
   output logic ref_rise
);

   localparam int PIPE_W = STAGES + 1;

   logic [PIPE_W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '0;
      end else begin
         pipe_q <= {pipe_q[PIPE_W-2:0], ref_in};
      end
   end

   assign ref_lvl  = pipe_q[STAGES-1];
   assign ref_rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/ref_divider_decode.sv
module ref_divider_decode
   import ref_divider_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] mode_req,
   input  logic              standby,
   output logic              osc_en,
   output logic              rcnt_en
);

   logic osc_n;
   logic rcnt_n;

   always_comb begin
      osc_n  = (refmode_e'(mode_req) == MD_XTAL_ON);
      rcnt_n = (refmode_e'(mode_req) != MD_XTAL_OFF) && !standby;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               osc_en  <= 1'b0;
               rcnt_en <= 1'b0;
            end else begin
               osc_en  <= osc_n;
               rcnt_en <= rcnt_n;
            end
         end
      end else begin : g_comb
         assign osc_en  = osc_n & rst_n;
         assign rcnt_en = rcnt_n & rst_n;
      end
   endgenerate

endmodule

// File: rtl/ref_divider_tgen.sv
module ref_divider_tgen
   import ref_divider_pkg::*;
#(
   parameter int RESET_CODE = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] mode_req,
   input  logic              ref_lvl,
   input  logic              ref_rise,
   output logic [CODE_W-1:0] act_code,
   output logic              ref_out
);

   localparam refmode_e BOOT_MODE = refmode_e'(RESET_CODE[CODE_W-1:0]);

   refmode_e          act_q, act_n;
   logic [HALF_W-1:0] cnt_q, cnt_n;
   logic              out_q, out_n;
   refmode_e          req;
   logic              at_top;

   assign req    = refmode_e'(mode_req);
   assign at_top = (cnt_q == half_len_m1(act_q));

   always_comb begin
      act_n = act_q;
      cnt_n = cnt_q;
      out_n = out_q;
      if (mode_is_static(act_q)) begin
         act_n = req;
         cnt_n = '0;
         out_n = 1'b0;
      end else if (act_q == MD_DIV1) begin
         cnt_n = '0;
         if (ref_rise) begin
            if (req != act_q) begin
               act_n = req;
               out_n = 1'b0;
            end else begin
               out_n = 1'b1;
            end
         end else begin
            out_n = out_q & ref_lvl;
         end
      end else if (ref_rise) begin
         if (at_top) begin
            cnt_n = '0;
            if (out_q) begin
               out_n = 1'b0;
            end else if (req == act_q) begin
               out_n = 1'b1;
            end else begin
               act_n = req;
            end
         end else begin
            cnt_n = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= BOOT_MODE;
         cnt_q <= '0;
         out_q <= 1'b0;
      end else begin
         act_q <= act_n;
         cnt_q <= cnt_n;
         out_q <= out_n;
      end
   end

   assign act_code = act_q;
   assign ref_out  = out_q;

endmodule

// File: rtl/ref_divider_ctl.sv
module ref_divider_ctl
   import ref_divider_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RESET_CODE  = 6,
   parameter bit REG_ENABLES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_in,
   input  logic [CODE_W-1:0] mode_code,
   input  logic              standby,
   output logic              osc_en,
   output logic              rcnt_en,
   output logic              ref_out
);

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 1..4");
      end
      if (RESET_CODE < 0 || RESET_CODE > 7) begin : g_bad_reset
         $error("RESET_CODE must be a 3-bit mode code");
      end
   endgenerate

   logic              ref_lvl;
   logic              ref_rise;
   logic [CODE_W-1:0] act_code;

   ref_divider_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_in   (ref_in),
      .ref_lvl  (ref_lvl),
      .ref_rise (ref_rise)
   );

   ref_divider_decode #(
      .REG_OUT (REG_ENABLES)
   ) i_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_req (mode_code),
      .standby  (standby),
      .osc_en   (osc_en),
      .rcnt_en  (rcnt_en)
   );

   ref_divider_tgen #(
      .RESET_CODE (RESET_CODE)
   ) i_tgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_req (mode_code),
      .ref_lvl  (ref_lvl),
      .ref_rise (ref_rise),
      .act_code (act_code),
      .ref_out  (ref_out)
   );

endmodule

// File: rtl/ref_divider_ctl_chk.sv
module ref_divider_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode_code,
   input logic       standby,
   input logic       osc_en,
   input logic       rcnt_en,
   input logic       ref_out,
   input logic       ref_rise,
   input logic [2:0] act_code
);

   // R2
   xtal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd0) |=> (!osc_en && !rcnt_en));

   // R3
   xtal_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd1 && !standby) |=> (osc_en && rcnt_en));

   // R4
   standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> !rcnt_en);

   // R5
   quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code <= 3'd2) |=> !ref_out);

   // R7
   rise_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_out) |-> $past(ref_rise));

   // R8
   switch_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_code != $past(act_code)) |-> !ref_out);

endmodule

bind ref_divider_ctl ref_divider_ctl_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_code (mode_code),
   .standby   (standby),
   .osc_en    (osc_en),
   .rcnt_en   (rcnt_en),
   .ref_out   (ref_out),
   .ref_rise  (ref_rise),
   .act_code  (act_code)
);

// File: tb/test_ref_divider_ctl.sv
module test_ref_divider_ctl;

   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_in = 1'b0;
   logic       standby = 1'b0;
   logic [2:0] mode_code = 3'd6;
   logic       osc_en, rcnt_en, ref_out;

   int checks = 0;
   int errors = 0;
   int ref_half = 3;
   bit done = 0;

   ref_divider_ctl i_ref_divider_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_in    (ref_in),
      .mode_code (mode_code),
      .standby   (standby),
      .osc_en    (osc_en),
      .rcnt_en   (rcnt_en),
      .ref_out   (ref_out)
   );

   always #4 clk = ~clk;

   initial begin
      forever begin
         repeat (ref_half) @(negedge clk);
         ref_in = ~ref_in;
      end
   end

   // behavioural reference model
   bit q[$];
   int m_code = 6;
   int m_cnt = 0;
   bit m_out = 0, m_osc = 0, m_rc = 0, m_boot = 1;

   initial repeat (SYNC + 1) q.push_back(1'b0);

   always @(posedge clk) begin
      bit s, d, rise;
      int half, req;
      req = int'(mode_code);
      if (!rst_n) begin
         q.delete();
         repeat (SYNC + 1) q.push_back(1'b0);
         m_code = 6; m_cnt = 0; m_out = 0; m_osc = 0; m_rc = 0; m_boot = 1;
      end else begin
         s = q[SYNC-1];
         d = q[SYNC];
         rise = s && !d;
         q.push_front(ref_in);
         void'(q.pop_back());
         if (m_code <= 2) begin
            if (m_code != req) m_boot = 0;
            m_code = req; m_cnt = 0; m_out = 0;
         end else if (m_code == 3) begin
            if (rise) begin
               if (req != 3) begin m_code = req; m_out = 0; m_boot = 0; end
               else m_out = 1;
            end else begin
               m_out = m_out && s;
            end
         end else begin
            half = 1 << (m_code - 4);
            if (rise) begin
               m_cnt++;
               if (m_cnt == half) begin
                  m_cnt = 0;
                  if (m_out) m_out = 0;
                  else if (req == m_code) m_out = 1;
                  else begin m_code = req; m_boot = 0; end
               end
            end
         end
         m_osc = (req == 1);
         m_rc  = (req != 0) && !standby;
      end
   end

   function automatic string out_tag();
      if (!rst_n || m_boot) return "R1";
      if (m_code != int'(mode_code)) return (m_code <= 2) ? "R9" : "R8";
      case (m_code)
         0: return "R2";
         1: return "R3";
         2: return "R5";
         3: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic string en_tag();
      if (!rst_n) return "R1";
      if (mode_code == 3'd0) return "R2";
      if (standby) return "R4";
      if (mode_code == 3'd1) return "R3";
      return "R5";
   endfunction

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (ref_out !== m_out) begin
            errors++;
            $display("FAIL %s ref_out t=%0t actual=%b expected=%b (mode %0d)",
                     out_tag(), $time, ref_out, m_out, m_code);
         end
         checks++;
         if (osc_en !== m_osc || rcnt_en !== m_rc) begin
            errors++;
            $display("FAIL %s enables t=%0t actual=%b%b expected=%b%b",
                     en_tag(), $time, osc_en, rcnt_en, m_osc, m_rc);
         end
      end
   end

   task automatic run(input logic [2:0] m, input logic s, input int n);
      @(negedge clk);
      mode_code = m;
      standby = s;
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      // R1 reset state held over several edges
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      run(3'd6, 0, 150);   // R7 divide by 8
      run(3'd7, 0, 300);   // R7 divide by 16, R8 switch
      run(3'd4, 1, 100);   // R4 standby in divide mode
      run(3'd5, 0, 120);
      run(3'd3, 0, 60);    // R6 follow
      ref_half = 5;
      run(3'd3, 1, 60);
      run(3'd7, 0, 250);
      run(3'd4, 0, 40);    // R8 mid-phase change
      run(3'd2, 0, 50);    // R5 quiet
      run(3'd1, 0, 40);    // R3 crystal on
      run(3'd1, 1, 40);    // R4 standby with oscillator kept
      run(3'd0, 1, 40);    // R2 shutdown in standby
      run(3'd0, 0, 30);    // R2 shutdown
      run(3'd6, 0, 200);   // R9 leave static mode
      run(3'd3, 0, 50);
      run(3'd5, 0, 150);
      ref_half = 2;
      run(3'd4, 0, 60);
      run(3'd7, 0, 200);
      run(3'd2, 1, 30);
      run(3'd3, 0, 40);
      // R1 second reset with a divide-by-16 request pending
      @(negedge clk);
      rst_n = 1'b0;
      mode_code = 3'd7;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      ref_half = 3;
      repeat (300) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

endmodule